// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Redundant-Digit Combiner

This block is the digital back end of a pipelined analog-to-digital converter built from identical 1.5-bit stages. In any clock cycle every stage reports a two-bit decision, but each decision belongs to a different sample: stage k is working on the sample that entered stage 1 k-1 cycles earlier. The block holds each stage's decision in a per-stage delay line of the right length, so that all decisions of one sample reach the combiner in the same cycle. It then adds them with a one-bit overlap into a single binary word of NSTAGES+1 bits.

Each stage digit takes the value 0, 1 or 2. A later stage that reports 2 carries into the bits above it, so an early stage whose comparator fired on the wrong side is repaired by the stages after it. Correction only ever adds. A new word leaves the block every clock after a fixed latency of NSTAGES cycles. A valid flag travels through the alignment registers with the data, and a flag marks words built from an illegal digit.

Top module: `pipe_bit_align`

## Requirements
- R1: Stage k (k = 1..NSTAGES) drives `codes_in[2k-1:2k-2]`. Code 00 means 0, 01 means 1 and 10 means 2. The output word is the sum over k of digit_k * 2^(NSTAGES-k).
- R2: Stage 1's code for a sample is driven in cycle t, and stage k's code for the same sample in cycle t+k-1. The word for that sample is on `out_word` in cycle t+NSTAGES, which is after NSTAGES rising edges.
- R3: Samples presented in consecutive cycles produce words in consecutive cycles, one per clock, with no gaps.
- R4: A digit of 2 from a later stage carries into the higher bits. The output is NSTAGES+1 bits wide and never exceeds 2^(NSTAGES+1)-2, so it never wraps.
- R5: The code 11 is illegal. It is counted as 10, and `out_err` is high for the word it contributes to, but only while that word is valid.
- R6: `out_valid` in cycle t+NSTAGES equals `in_valid` in cycle t. Words from slots without valid input leave `out_valid` and `out_err` low.
- R7: A synchronous active-high `rst` clears the outputs and every alignment register. After reset, `out_valid` stays low until newly valid data has passed through the full pipeline.
- R8: Codes may come from stages that follow the 1.5-bit residue rule, with both comparator thresholds of a stage shifted by less than VREF/4. The word then stays within 1 LSB of 2^NSTAGES*vin/VREF + 2^NSTAGES - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the sample whose stage-1 code is present this cycle |
| codes_in | input | 2*NSTAGES | Current two-bit decision of every stage, stage 1 in the low bits |
| out_valid | output | 1 | Aligned word is valid |
| out_word | output | NSTAGES+1 | Corrected binary word |
| out_err | output | 1 | A valid word used an illegal 11 code |

## Verification
The combiner is driven with skewed code streams, so that each stage's code for one sample arrives in a different cycle. Word-level patterns are used, for example all-zero, all-mid, all-high, a single high digit at either end, and carry-producing mixes. Two different digit sets that encode the same value tell true overlap addition apart from concatenation. Back-to-back and gapped streams separate throughput from valid tracking. A stream of illegal codes under a low valid shows that the error flag is gated. A residue-equation model with shifted comparator thresholds creates codes in which early decisions are wrong, which shows the redundancy repairing them to within one LSB. A reset taken in the middle of a stream shows that no stale valid survives in the alignment registers.

// File: rtl/pipe_align_pkg.sv
`timescale 1ns/1ps
package pipe_align_pkg;

    typedef enum logic [1:0] {
        DIG_LOW  = 2'b00,
        DIG_MID  = 2'b01,
        DIG_HIGH = 2'b10,
        DIG_BAD  = 2'b11
    } stage_dig_e;

    typedef struct packed {
        logic       bad;
        logic [1:0] dig;
    } stage_tok_t;

    localparam int TOK_W = $bits(stage_tok_t);

    // Illegal 11 is folded onto the highest legal digit and flagged.
    function automatic stage_tok_t clean_code(input logic [1:0] raw);
        stage_tok_t t;
        t.bad = (raw == DIG_BAD);
        t.dig = t.bad ? DIG_HIGH : raw;
        return t;
    endfunction

endpackage

// File: rtl/pa_delay_line.sv
`timescale 1ns/1ps
module pa_delay_line #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] taps [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= din;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign dout = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pa_stage_lane.sv
`timescale 1ns/1ps
module pa_stage_lane
    import pipe_align_pkg::*;
#(
    parameter int NSTAGES = 8,
    parameter int IDX     = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       raw_code,
    output logic [TOK_W-1:0] tok_aligned
);

    localparam int LAG = NSTAGES - 1 - IDX;

    stage_tok_t tok_now;

    always_comb tok_now = clean_code(raw_code);

    pa_delay_line #(.WIDTH(TOK_W), .DEPTH(LAG)) u_dly (
        .clk (clk),
        .rst (rst),
        .din (tok_now),
        .dout(tok_aligned)
    );

endmodule

// File: rtl/pa_overlap_sum.sv
`timescale 1ns/1ps
module pa_overlap_sum
    import pipe_align_pkg::*;
#(
    parameter int NSTAGES = 8
) (
    input  logic [NSTAGES*TOK_W-1:0] toks,
    output logic [NSTAGES:0]         sum,
    output logic                     any_bad
);

    localparam int OUT_W = NSTAGES + 1;

    always_comb begin
        sum     = '0;
        any_bad = 1'b0;
        for (int k = 0; k < NSTAGES; k++) begin
            stage_tok_t t;
            t       = stage_tok_t'(toks[k*TOK_W +: TOK_W]);
            sum     = sum + (OUT_W'(t.dig) << (NSTAGES - 1 - k));
            any_bad = any_bad | t.bad;
        end
    end

endmodule

// File: rtl/pipe_bit_align.sv
`timescale 1ns/1ps
module pipe_bit_align
    import pipe_align_pkg::*;
#(
    parameter int NSTAGES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2*NSTAGES-1:0] codes_in,
    output logic                 out_valid,
    output logic [NSTAGES:0]     out_word,
    output logic                 out_err
);

    localparam int OUT_W = NSTAGES + 1;
    localparam int VLAG  = NSTAGES - 1;

    logic [NSTAGES*TOK_W-1:0] toks_al;
    logic [OUT_W-1:0]         sum_al;
    logic                     bad_al;
    logic                     vld_al;

    generate
        for (genvar k = 0; k < NSTAGES; k++) begin : g_lane
            pa_stage_lane #(.NSTAGES(NSTAGES), .IDX(k)) u_lane (
                .clk        (clk),
                .rst        (rst),
                .raw_code   (codes_in[2*k +: 2]),
                .tok_aligned(toks_al[k*TOK_W +: TOK_W])
            );
        end
    endgenerate

    pa_delay_line #(.WIDTH(1), .DEPTH(VLAG)) u_vld (
        .clk (clk),
        .rst (rst),
        .din (in_valid),
        .dout(vld_al)
    );

    pa_overlap_sum #(.NSTAGES(NSTAGES)) u_sum (
        .toks   (toks_al),
        .sum    (sum_al),
        .any_bad(bad_al)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= vld_al;
            out_word  <= sum_al;
            out_err   <= vld_al & bad_al;
        end
    end

endmodule

// File: rtl/pipe_bit_align_chk.sv
`timescale 1ns/1ps
module pipe_bit_align_chk #(
    parameter int NSTAGES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [NSTAGES:0] out_word,
    input logic             out_err
);

    localparam int SAT = NSTAGES + 1;
    localparam int CW  = $clog2(SAT + 1) + 1;
    localparam logic [NSTAGES:0] WMAX = {(NSTAGES+1){1'b1}} - 1'b1;

    logic [CW-1:0] since_vld;

    always_ff @(posedge clk) begin
        if (rst)                     since_vld <= CW'(SAT);
        else if (in_valid)           since_vld <= CW'(1);
        else if (since_vld < CW'(SAT)) since_vld <= since_vld + 1'b1;
    end

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        out_word <= WMAX);

    a_r5_err_gated: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    a_r6_valid_arrives: assert property (@(posedge clk) disable iff (rst)
        (since_vld == CW'(NSTAGES)) |-> out_valid);

    a_r6_valid_quiet: assert property (@(posedge clk) disable iff (rst)
        (since_vld == CW'(SAT)) |-> !out_valid);

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_word == '0 && !out_err));

endmodule

bind pipe_bit_align pipe_bit_align_chk #(.NSTAGES(NSTAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_err  (out_err)
);

// File: tb/test_pipe_bit_align.sv
`timescale 1ns/1ps
module test_pipe_bit_align;

    localparam int N   = 8;
    localparam int OW  = N + 1;
    localparam int CWD = 2 * N;
    localparam int NV  = 12;

    // {codes, err, expected word}
    localparam logic [CWD+1+OW-1:0] VEC [NV] = '{
        {16'h5555, 1'b0, 9'd255},
        {16'h0000, 1'b0, 9'd0},
        {16'hAAAA, 1'b0, 9'd510},
        {16'h0002, 1'b0, 9'd256},
        {16'h8000, 1'b0, 9'd2},
        {16'hAAA9, 1'b0, 9'd382},
        {16'hAAA8, 1'b0, 9'd254},
        {16'h5552, 1'b0, 9'd319},
        {16'h2222, 1'b0, 9'd340},
        {16'h9999, 1'b0, 9'd340},
        {16'h0030, 1'b1, 9'd64},
        {16'hFFFF, 1'b1, 9'd510}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [CWD-1:0]  codes_in = '0;
    logic            out_valid;
    logic [OW-1:0]   out_word;
    logic            out_err;

    int n_chk = 0;
    int n_bad = 0;

    logic [CWD-1:0] s_codes [16];
    logic           s_vld   [16];
    logic           s_err   [16];
    int             s_exp   [16];
    logic           s_an    [16];
    real            s_ideal [16];

    always #2 clk = ~clk;

    pipe_bit_align #(.NSTAGES(N)) i_pipe_bit_align (
        .clk(clk), .rst(rst), .in_valid(in_valid), .codes_in(codes_in),
        .out_valid(out_valid), .out_word(out_word), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real thr_shift(input int k);
        if (k == 1) return 0.2;
        if (k == 3) return -0.15;
        if (k == 5) return 0.1;
        return 0.0;
    endfunction

    // Residue model of the analog stages, VREF = 1.
    function automatic logic [CWD-1:0] model_codes(input real vin);
        logic [CWD-1:0] c = '0;
        real v = vin;
        for (int k = 0; k < N; k++) begin
            real hi = 0.25 + thr_shift(k);
            real lo = -0.25 + thr_shift(k);
            if (v > hi) begin
                c[2*k +: 2] = 2'b10; v = 2.0 * v - 1.0;
            end else if (v >= lo) begin
                c[2*k +: 2] = 2'b01; v = 2.0 * v;
            end else begin
                c[2*k +: 2] = 2'b00; v = 2.0 * v + 1.0;
            end
        end
        return c;
    endfunction

    task automatic run_stream(input int cnt);
        for (int t = 0; t <= cnt + N; t++) begin
            @(negedge clk);
            if (t >= N && t - N < cnt) begin
                int s = t - N;
                chk(out_valid == s_vld[s], "R6 R2 valid", out_valid, s_vld[s]);
                if (s_vld[s]) begin
                    if (s_an[s]) begin
                        real d = real'(out_word) - s_ideal[s];
                        chk(d <= 1.0001 && d >= -1.0001, "R8 word", out_word, int'(s_ideal[s]));
                    end else begin
                        chk(out_word == OW'(s_exp[s]), "R1 R2 R3 R4 word", out_word, s_exp[s]);
                    end
                    chk(out_err == s_err[s], "R5 err", out_err, s_err[s]);
                end else begin
                    chk(out_err == 1'b0, "R5 R6 err on invalid", out_err, 0);
                end
            end
            for (int k = 0; k < N; k++) begin
                int idx = t - k;
                codes_in[2*k +: 2] = (idx >= 0 && idx < cnt) ? s_codes[idx][2*k +: 2] : 2'b00;
            end
            in_valid = (t < cnt) ? s_vld[t] : 1'b0;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        real vins [8] = '{-0.99, -0.5, 0.0, 0.3, 0.65, 0.999, 0.22, -0.73};

        // R7: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
        chk(out_word == '0, "R7 reset word", out_word, 0);
        chk(out_err == 1'b0, "R7 reset err", out_err, 0);
        rst = 1'b0;

        // Vector table, back to back
        for (int i = 0; i < NV; i++) begin
            s_codes[i] = VEC[i][CWD+OW:OW+1];
            s_err[i]   = VEC[i][OW];
            s_exp[i]   = int'(VEC[i][OW-1:0]);
            s_vld[i]   = 1'b1;
            s_an[i]    = 1'b0;
            s_ideal[i] = 0.0;
        end
        run_stream(NV);

        // Gapped valid, illegal codes under low valid
        s_codes[0] = 16'h0002; s_vld[0] = 1; s_err[0] = 0; s_exp[0] = 256;
        s_codes[1] = 16'hFFFF; s_vld[1] = 0; s_err[1] = 0; s_exp[1] = 0;
        s_codes[2] = 16'h9999; s_vld[2] = 1; s_err[2] = 0; s_exp[2] = 340;
        s_codes[3] = 16'h0000; s_vld[3] = 0; s_err[3] = 0; s_exp[3] = 0;
        s_codes[4] = 16'h5555; s_vld[4] = 1; s_err[4] = 0; s_exp[4] = 255;
        for (int i = 0; i < 5; i++) s_an[i] = 1'b0;
        run_stream(5);

        // R8: analog model with shifted comparator thresholds
        for (int i = 0; i < 8; i++) begin
            s_codes[i] = model_codes(vins[i]);
            s_vld[i]   = 1'b1;
            s_err[i]   = 1'b0;
            s_exp[i]   = 0;
            s_an[i]    = 1'b1;
            s_ideal[i] = 256.0 * vins[i] + 255.0;
        end
        run_stream(8);

        // R7: reset in mid-flight clears alignment registers
        codes_in = 16'hAAAA;
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < N + 2; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 no stale valid", out_valid, 0);
            chk(out_err == 1'b0, "R7 no stale err", out_err, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule